// File: doc/BRIEF.md
# Mirrored Interrupt Status Register File

This block is a small byte-addressed slice of the configuration space of a two-channel disk interface controller. Each channel owns one interrupt flag, and software can see that flag in two registers: a per-channel status register and a shared mode register. The block keeps both views identical. It lets software clear a flag by writing a one to either view. It also applies a per-channel block mask and drives a single level-sensitive interrupt line.

The flags follow the channels' interrupt request levels. When a request level changes, the flag takes the new level. A flag that software has cleared stays clear while the request level stays high. The block mask bits are loaded through a separate strobe that shares the write data bus, so the configuration write path cannot change them. A fourth register holds the channel enable bits. It resets with channel 0 enabled, and channel 1 is enabled only when a parameter asks for it.

Top module: `imr_regfile`

## Requirements
- R1: After reset, every flag and block bit is 0 and `irq_out` is 0.
- R2: Read layout. Offset 0x50 returns the channel 0 flag in bit 2. Offset 0x57 returns the channel 1 flag in bit 4. Offset 0x71 returns the channel 0 flag in bit 2, the channel 1 flag in bit 3, block 0 in bit 4 and block 1 in bit 5. Every other bit of these registers reads 0, and any offset other than 0x50, 0x51, 0x57 and 0x71 reads 0x00.
- R3: When `chan_irq_req[i]` changes, flag i takes its new value at the sampling edge, and all read copies show it from that edge on.
- R4: A configuration write to 0x50 with bit 2 set clears the channel 0 flag in both copies. A write to 0x57 with bit 4 set clears the channel 1 flag in both copies.
- R5: A configuration write to 0x71 clears the channel 0 flag when bit 2 is set and the channel 1 flag when bit 3 is set, and the status registers at 0x50 and 0x57 follow.
- R6: Configuration writes to 0x50, 0x57 and 0x71 have no other effect. Zero flag bits and all other bits, including the block bits at 0x71, change nothing.
- R7: When `blk_we` is high, `cfg_wdata[4]` loads block 0 and `cfg_wdata[5]` loads block 1. The flags are unchanged.
- R8: One clock after the state changes, `irq_out` equals (flag0 AND NOT block0) OR (flag1 AND NOT block1).
- R9: A request level that rises in the same cycle as a write-one-to-clear of the same flag leaves the flag set.
- R10: Offset 0x51 is a read/write byte. It resets to 0x04, or to 0x0C when `SECONDARY_EN` is 1.
- R11: A request level that stays high does not set its flag again after software has cleared it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration write offset |
| cfg_wdata | input | 8 | Write data, shared with the block mask strobe |
| blk_we | input | 1 | Load the block mask bits from cfg_wdata[5:4] |
| cfg_raddr | input | 8 | Read offset |
| cfg_rdata | output | 8 | Read data, combinational from state |
| chan_irq_req | input | 2 | Per-channel interrupt request levels |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
The assertions assume the following about the inputs:
- Request levels, strobes and write data are synchronous to `clk`.
- A request level can change at the same time as any configuration write or mask load.
- A level that is already high while reset is active may set its flag at the first edge after reset.

The assertions that describe clearing therefore claim it only while the request level is low.

The stimulus drives every input on the falling edge. It toggles the request levels sparsely, so that flags persist long enough to be cleared. It aims most writes at the four decoded offsets and sends the rest to unused offsets.

// File: rtl/imr_pkg.sv
package imr_pkg;
   // Bit positions are fixed by the register layout.
   localparam int STAT0_FLAG_BIT = 2;
   localparam int STAT1_FLAG_BIT = 4;
   localparam int MODE_FLAG_LSB  = 2;
   localparam int MODE_BLK_LSB   = 4;
   localparam int CTRL_EN0_BIT   = 2;
   localparam int CTRL_EN1_BIT   = 3;
   localparam int NUM_CHAN       = 2;
endpackage

// File: rtl/imr_flag_cell.sv
module imr_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic clr,
   output logic flag
);
   logic prev_q;
   logic flag_q;
   logic level_evt;

   assign level_evt = req ^ prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         prev_q <= req;
         if (level_evt)
            flag_q <= req;        // a level change outranks a clear
         else if (clr)
            flag_q <= 1'b0;
      end
   end

   assign flag = flag_q;
endmodule

// File: rtl/imr_cfg_decode.sv
module imr_cfg_decode
   import imr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] STAT0_ADDR = 'h50,
   parameter logic [ADDR_W-1:0] STAT1_ADDR = 'h57,
   parameter logic [ADDR_W-1:0] MODE_ADDR  = 'h71,
   parameter logic [ADDR_W-1:0] CTRL_ADDR  = 'h51
) (
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [NUM_CHAN-1:0] clr,
   output logic              ctrl_we
);
   logic hit_s0, hit_s1, hit_md;

   always_comb begin
      hit_s0  = cfg_we && (cfg_addr == STAT0_ADDR);
      hit_s1  = cfg_we && (cfg_addr == STAT1_ADDR);
      hit_md  = cfg_we && (cfg_addr == MODE_ADDR);
      ctrl_we = cfg_we && (cfg_addr == CTRL_ADDR);
      clr[0]  = (hit_s0 && cfg_wdata[STAT0_FLAG_BIT]) ||
                (hit_md && cfg_wdata[MODE_FLAG_LSB]);
      clr[1]  = (hit_s1 && cfg_wdata[STAT1_FLAG_BIT]) ||
                (hit_md && cfg_wdata[MODE_FLAG_LSB+1]);
   end
endmodule

// File: rtl/imr_read_mux.sv
module imr_read_mux
   import imr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] STAT0_ADDR = 'h50,
   parameter logic [ADDR_W-1:0] STAT1_ADDR = 'h57,
   parameter logic [ADDR_W-1:0] MODE_ADDR  = 'h71,
   parameter logic [ADDR_W-1:0] CTRL_ADDR  = 'h51
) (
   input  logic [ADDR_W-1:0]   raddr,
   input  logic [NUM_CHAN-1:0] flag,
   input  logic [NUM_CHAN-1:0] blk,
   input  logic [DATA_W-1:0]   ctrl,
   output logic [DATA_W-1:0]   rdata
);
   always_comb begin
      rdata = '0;
      if (raddr == STAT0_ADDR) begin
         rdata[STAT0_FLAG_BIT] = flag[0];
      end else if (raddr == STAT1_ADDR) begin
         rdata[STAT1_FLAG_BIT] = flag[1];
      end else if (raddr == MODE_ADDR) begin
         rdata[MODE_FLAG_LSB +: NUM_CHAN] = flag;
         rdata[MODE_BLK_LSB  +: NUM_CHAN] = blk;
      end else if (raddr == CTRL_ADDR) begin
         rdata = ctrl;
      end
   end
endmodule

// File: rtl/imr_irq_combine.sv
module imr_irq_combine
   import imr_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CHAN-1:0] flag,
   input  logic [NUM_CHAN-1:0] blk,
   output logic                irq
);
   logic irq_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(flag & ~blk);
   end
   assign irq = irq_q;
endmodule

// File: rtl/imr_regfile.sv
module imr_regfile
   import imr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] STAT0_ADDR = 'h50,
   parameter logic [ADDR_W-1:0] CTRL_ADDR  = 'h51,
   parameter logic [ADDR_W-1:0] STAT1_ADDR = 'h57,
   parameter logic [ADDR_W-1:0] MODE_ADDR  = 'h71,
   parameter bit SECONDARY_EN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              blk_we,
   input  logic [ADDR_W-1:0] cfg_raddr,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic [NUM_CHAN-1:0] chan_irq_req,
   output logic              irq_out
);
   localparam logic [DATA_W-1:0] CTRL_RST =
      DATA_W'((1 << CTRL_EN0_BIT) | (SECONDARY_EN ? (1 << CTRL_EN1_BIT) : 0));

   if (DATA_W < 8) begin : g_bad_width
      $error("imr_regfile: DATA_W must be at least 8");
   end
   if (STAT0_ADDR == STAT1_ADDR || STAT0_ADDR == MODE_ADDR ||
       STAT1_ADDR == MODE_ADDR || CTRL_ADDR == MODE_ADDR ||
       CTRL_ADDR == STAT0_ADDR || CTRL_ADDR == STAT1_ADDR) begin : g_bad_addr
      $error("imr_regfile: register offsets must be distinct");
   end

   logic [NUM_CHAN-1:0] clr;
   logic [NUM_CHAN-1:0] flag_q;
   logic [NUM_CHAN-1:0] blk_q;
   logic [DATA_W-1:0]   ctrl_q;
   logic                ctrl_we;

   imr_cfg_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .STAT0_ADDR(STAT0_ADDR), .STAT1_ADDR(STAT1_ADDR),
      .MODE_ADDR(MODE_ADDR), .CTRL_ADDR(CTRL_ADDR)
   ) u_dec (
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .clr(clr), .ctrl_we(ctrl_we)
   );

   for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
      imr_flag_cell u_cell (
         .clk(clk), .rst_n(rst_n),
         .req(chan_irq_req[ch]), .clr(clr[ch]),
         .flag(flag_q[ch])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_q  <= '0;
         ctrl_q <= CTRL_RST;
      end else begin
         if (blk_we)  blk_q  <= cfg_wdata[MODE_BLK_LSB +: NUM_CHAN];
         if (ctrl_we) ctrl_q <= cfg_wdata;
      end
   end

   imr_read_mux #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .STAT0_ADDR(STAT0_ADDR), .STAT1_ADDR(STAT1_ADDR),
      .MODE_ADDR(MODE_ADDR), .CTRL_ADDR(CTRL_ADDR)
   ) u_rd (
      .raddr(cfg_raddr), .flag(flag_q), .blk(blk_q),
      .ctrl(ctrl_q), .rdata(cfg_rdata)
   );

   imr_irq_combine u_irq (
      .clk(clk), .rst_n(rst_n), .flag(flag_q), .blk(blk_q), .irq(irq_out)
   );
endmodule

// File: rtl/imr_regfile_checker.sv
module imr_regfile_checker
   import imr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] STAT0_ADDR = 'h50,
   parameter logic [ADDR_W-1:0] STAT1_ADDR = 'h57,
   parameter logic [ADDR_W-1:0] MODE_ADDR  = 'h71
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cfg_we,
   input logic [ADDR_W-1:0]   cfg_addr,
   input logic [DATA_W-1:0]   cfg_wdata,
   input logic                blk_we,
   input logic [NUM_CHAN-1:0] chan_irq_req,
   input logic [NUM_CHAN-1:0] flag,
   input logic [NUM_CHAN-1:0] blk,
   input logic                irq_out
);
   for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_ch
      // R3 and R9: a rising request always leaves the flag set
      assert_rise_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (chan_irq_req[ch] && !$past(chan_irq_req[ch])) |=> flag[ch]);
      assert_fall_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (!chan_irq_req[ch] && $past(chan_irq_req[ch])) |=> !flag[ch]);
   end

   assert_stat_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == STAT0_ADDR && cfg_wdata[STAT0_FLAG_BIT] && !chan_irq_req[0])
      |=> !flag[0]);

   assert_mode_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == MODE_ADDR && cfg_wdata[MODE_FLAG_LSB+1] && !chan_irq_req[1])
      |=> !flag[1]);

   assert_blk_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      blk_we |=> (blk == $past(cfg_wdata[MODE_BLK_LSB +: NUM_CHAN])));

   assert_blk_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_we |=> $stable(blk));

   assert_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == $past(|(flag & ~blk)));
endmodule

bind imr_regfile imr_regfile_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .STAT0_ADDR(STAT0_ADDR), .STAT1_ADDR(STAT1_ADDR), .MODE_ADDR(MODE_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
   .cfg_wdata(cfg_wdata), .blk_we(blk_we), .chan_irq_req(chan_irq_req),
   .flag(flag_q), .blk(blk_q), .irq_out(irq_out)
);

// File: tb/imr_regfile_bench.sv
`timescale 1ns/1ps
module imr_regfile_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic       blk_we = 1'b0;
   logic [7:0] cfg_raddr = '0;
   logic [7:0] cfg_rdata;
   logic [1:0] chan_irq_req = '0;
   logic       irq_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   // reference state
   logic [1:0] m_flag, m_prev, m_blk;
   logic [7:0] m_ctrl;
   logic       m_irq;

   always #4 clk = ~clk;   // 125 MHz

   imr_regfile u_imr_regfile (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .blk_we(blk_we), .cfg_raddr(cfg_raddr),
      .cfg_rdata(cfg_rdata), .chan_irq_req(chan_irq_req), .irq_out(irq_out)
   );

   function automatic logic [7:0] exp_read(input logic [7:0] a);
      logic [7:0] r = 8'h00;
      case (a)
         8'h50: r[2] = m_flag[0];
         8'h57: r[4] = m_flag[1];
         8'h71: begin r[3:2] = m_flag; r[5:4] = m_blk; end
         8'h51: r = m_ctrl;
         default: r = 8'h00;
      endcase
      return r;
   endfunction

   task automatic model_step();
      logic [1:0] clr;
      m_irq = |(m_flag & ~m_blk);
      clr[0] = cfg_we && ((cfg_addr == 8'h50 && cfg_wdata[2]) ||
                          (cfg_addr == 8'h71 && cfg_wdata[2]));
      clr[1] = cfg_we && ((cfg_addr == 8'h57 && cfg_wdata[4]) ||
                          (cfg_addr == 8'h71 && cfg_wdata[3]));
      for (int c = 0; c < 2; c++) begin
         if (chan_irq_req[c] != m_prev[c]) m_flag[c] = chan_irq_req[c];
         else if (clr[c])                  m_flag[c] = 1'b0;
         m_prev[c] = chan_irq_req[c];
      end
      if (blk_we) m_blk = cfg_wdata[5:4];
      if (cfg_we && cfg_addr == 8'h51) m_ctrl = cfg_wdata;
   endtask

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // one clock: drive at falling edge, compare after the rising edge
   task automatic cyc(input logic we, input logic [7:0] a, input logic [7:0] d,
                      input logic bw, input logic [1:0] rq, input logic [7:0] ra,
                      input string tag);
      @(negedge clk);
      cfg_we = we; cfg_addr = a; cfg_wdata = d; blk_we = bw;
      chan_irq_req = rq; cfg_raddr = ra;
      model_step();
      @(posedge clk);
      #2;
      chk({tag, " rdata"}, cfg_rdata, exp_read(ra));
      chk({tag, " irq R8"}, {7'b0, irq_out}, {7'b0, m_irq});
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [1:0] rq;
      void'($urandom(32'd20240611));
      m_flag = '0; m_prev = '0; m_blk = '0; m_ctrl = 8'h04; m_irq = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 / R10: reset values
      cfg_raddr = 8'h51; #1;
      chk("R10 reset ctrl", cfg_rdata, 8'h04);
      cfg_raddr = 8'h71; #1;
      chk("R1 reset mode", cfg_rdata, 8'h00);
      chk("R1 reset irq", {7'b0, irq_out}, 8'h00);
      rst_n = 1'b1;

      cyc(0, 8'h00, 8'h00, 0, 2'b01, 8'h50, "R3 rise ch0 status copy");
      cyc(0, 8'h00, 8'h00, 0, 2'b01, 8'h71, "R3 rise ch0 mode copy");
      cyc(1, 8'h50, 8'h04, 0, 2'b01, 8'h71, "R4 clear via 0x50");
      cyc(0, 8'h00, 8'h00, 0, 2'b01, 8'h50, "R11 held level no reset");
      cyc(0, 8'h00, 8'h00, 0, 2'b11, 8'h57, "R3 rise ch1");
      cyc(1, 8'h57, 8'hEF, 0, 2'b11, 8'h57, "R6 other bits 0x57");
      cyc(1, 8'h71, 8'hF3, 0, 2'b11, 8'h71, "R6 other bits 0x71");
      cyc(1, 8'h50, 8'hFB, 0, 2'b11, 8'h71, "R6 other bits 0x50");
      cyc(0, 8'h00, 8'h20, 1, 2'b11, 8'h71, "R7 block ch1");
      cyc(0, 8'h00, 8'h00, 0, 2'b11, 8'h71, "R7 flags kept R8 masked");
      cyc(1, 8'h71, 8'h08, 0, 2'b11, 8'h57, "R5 clear ch1 via 0x71");
      cyc(0, 8'h00, 8'h00, 0, 2'b10, 8'h50, "R3 fall ch0");
      cyc(1, 8'h71, 8'h04, 0, 2'b11, 8'h50, "R9 rise beats clear");
      cyc(1, 8'h71, 8'h04, 0, 2'b11, 8'h50, "R5 clear ch0 via 0x71");
      cyc(1, 8'h51, 8'h5A, 0, 2'b11, 8'h51, "R10 ctrl write");
      cyc(0, 8'h00, 8'h00, 0, 2'b11, 8'h33, "R2 unused offset");
      cyc(0, 8'h00, 8'h00, 1, 2'b00, 8'h71, "R7 clear blocks");

      for (int i = 0; i < 4000; i++) begin
         logic [7:0] a, ra;
         case ($urandom % 5)
            0: a = 8'h50; 1: a = 8'h57; 2: a = 8'h71; 3: a = 8'h51;
            default: a = 8'($urandom);
         endcase
         case ($urandom % 5)
            0: ra = 8'h50; 1: ra = 8'h57; 2, 3: ra = 8'h71; 4: ra = 8'h51;
            default: ra = 8'h00;
         endcase
         rq = chan_irq_req;
         if ($urandom % 6 == 0) rq[0] = ~rq[0];
         if ($urandom % 6 == 0) rq[1] = ~rq[1];
         cyc(($urandom % 3) == 0, a, 8'($urandom), ($urandom % 8) == 0, rq, ra,
             "R2/R3/R4/R5/R6/R7/R9 random");
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule